// File: doc/BRIEF.md
# Transfer-Unit Fill Calculator

This block works out how a display stream is packed into fixed-size transfer units on a multi-lane serial link. From the pixel clock (kHz), bits per pixel, active lane count and link symbol rate it derives the per-lane fill ratio. It then walks the candidate unit sizes and, for each, encodes the average count of valid symbols per unit as an integer part plus a reciprocal-style fraction. The candidate whose encoding lands closest to the true fill is kept, and an extra-symbol field is derived from it.

A request is a single `start` pulse taken while `busy` is low. The operands are captured on that edge, so the caller may change them afterwards. There is no back-pressure: a `start` that arrives while `busy` is high is dropped. The result appears as two packed words together with a one-cycle `done` pulse, and it holds until the next completion. All divisions share one serial restoring divider, so a request takes a few thousand cycles.

Top module: `tu_fill_calc`

## Requirements
- R1: After reset, `busy`, `done` and `fail` are low and both `tu_word` and `fill_word` are zero.
- R2: A `start` seen while `busy` is low raises `busy` on the next cycle. `busy` stays high until the cycle in which `done` is high for exactly one cycle, and in that cycle `busy` is low. A `start` seen while `busy` is high has no effect on the result.
- R3: The per-lane rate is floor(floor(pclk_khz*bpp/8)/n), where n is 1 for lane code 1, 2 for lane code 2 and 4 for every other code. The ratio is floor(rate*100000/L), where L is 270000 when `rate_hi` is 1 and 162000 otherwise.
- R4: Unit sizes are tried from 64 down to 32. A candidate's error is (added amount − remainder). It replaces the best only when that error is strictly below the best so far, which starts at 6400000. The walk ends after a zero-error candidate or after size 32, so on a tie the larger size wins.
- R5: For each size T, target = ratio*T, integer = floor(target/100000) and remainder = target mod 100000. When the remainder is at least 50000, let c = ceil(100000/(100000−remainder)). If c ≤ 15: mode 1, fraction c, added = 100000 − floor(100000/c). Otherwise: mode 0, fraction 1, added = 100000.
- R6: When 0 < remainder < 50000: mode 0, fraction = min(floor(100000/remainder), 15), added = floor(100000/fraction).
- R7: When the remainder is zero: mode 0, fraction 1, the integer is reduced by one, and the error is zero.
- R8: The extra field is floor(floor((100000−ratio)*T*ratio/100000)/100000) + 6 for the chosen T, truncated to 6 bits.
- R9: `tu_word` carries T in bits 8:2, with every other bit zero. `fill_word` carries mode in bit 24, fraction in bits 19:16, the low 7 bits of the integer in bits 14:8 and the extra field in bits 5:0, with every other bit zero.
- R10: If no candidate beats the initial bound, `fail` is 1 at `done` and both words keep their earlier values. Otherwise `fail` is 0 at `done`.
- R11: `tu_word`, `fill_word` and `fail` change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken when `busy` is low |
| pclk_khz | input | 20 | Pixel clock in kHz |
| bpp | input | 8 | Bits per pixel |
| lanes | input | 3 | Active lane code (1, 2, else 4) |
| rate_hi | input | 1 | 1 selects 270000, 0 selects 162000 |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | No candidate found at the last completion |
| tu_word | output | 32 | Packed unit size |
| fill_word | output | 32 | Packed mode, fraction, integer and extra field |

## Verification
`busy` is due one cycle after an accepted `start`. The bench samples it at the next falling edge. The packed words and `fail` are due in the cycle `done` rises, and that cycle comes a data-dependent number of cycles later, set by how many sizes are walked and which encoding branch each one takes. The bench therefore polls `done` at falling edges under a per-request limit and compares the words in that same cycle. One cycle later it checks that `done` has fallen. It checks again many cycles after a completion, with the inputs changed, to confirm the words are held.

// File: rtl/tu_calc_pkg.sv
package tu_calc_pkg;
  localparam int unsigned SYM        = 100000;
  localparam int unsigned HALF_SYM   = 50000;
  localparam int unsigned RATE_LO    = 162000;
  localparam int unsigned RATE_HI    = 270000;
  localparam int unsigned FRAC_CAP   = 15;
  localparam int unsigned EXTRA_BIAS = 6;
  localparam int unsigned INIT_BOUND = 64 * SYM;

  localparam int TU_LSB    = 2;
  localparam int MODE_BIT  = 24;
  localparam int FRAC_LSB  = 16;
  localparam int INT_LSB   = 8;
  localparam int EXTRA_LSB = 0;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RATIO,
    ST_TV,
    ST_HI_CEIL,
    ST_HI_RECIP,
    ST_LO_RECIP,
    ST_LO_ADD,
    ST_EVAL,
    ST_FIN,
    ST_EXTRA1,
    ST_EXTRA2
  } calc_state_e;
endpackage

// File: rtl/tu_divider.sv
module tu_divider #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int CNT_W = $clog2(W + 1);
  localparam int W2    = 2 * W;

  logic [W-1:0]     quo_r, rem_r, dsr_r, dvd_r;
  logic [CNT_W-1:0] cnt_r;
  logic             run_r, done_r;
  logic [W:0]       shifted, trial;

  assign shifted = {rem_r, quo_r[W-1]};
  assign trial   = shifted - {1'b0, dsr_r};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo_r  <= '0;
      rem_r  <= '0;
      dsr_r  <= '0;
      dvd_r  <= '0;
      cnt_r  <= '0;
      run_r  <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (start) begin
        quo_r <= dividend;
        dvd_r <= dividend;
        rem_r <= '0;
        dsr_r <= divisor;
        cnt_r <= CNT_W'(W);
        run_r <= 1'b1;
      end else if (run_r) begin
        if (!trial[W]) begin
          rem_r <= trial[W-1:0];
          quo_r <= {quo_r[W-2:0], 1'b1};
        end else begin
          rem_r <= shifted[W-1:0];
          quo_r <= {quo_r[W-2:0], 1'b0};
        end
        cnt_r <= cnt_r - 1'b1;
        if (cnt_r == CNT_W'(1)) begin
          run_r  <= 1'b0;
          done_r <= 1'b1;
        end
      end
    end
  end

  assign done      = done_r;
  assign quotient  = quo_r;
  assign remainder = rem_r;

  // R3: every quotient and remainder reconstruct the captured dividend
  a_r3_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (W2'(quo_r) * W2'(dsr_r) + W2'(rem_r)) == W2'(dvd_r));
  // R3: remainder is below the divisor
  a_r3_div_rem_small: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rem_r < dsr_r);
  // R3: the controller never restarts a running division
  a_r3_div_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run_r);
endmodule

// File: rtl/tu_best_track.sv
module tu_best_track #(
  parameter int W      = 64,
  parameter int TU_W   = 7,
  parameter int INT_W  = 7,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cand_valid,
  input  logic [W-1:0]      cand_err,
  input  logic [TU_W-1:0]   cand_tu,
  input  logic [INT_W-1:0]  cand_int,
  input  logic [FRAC_W-1:0] cand_frac,
  input  logic              cand_mode,
  output logic              found,
  output logic [TU_W-1:0]   best_tu,
  output logic [INT_W-1:0]  best_int,
  output logic [FRAC_W-1:0] best_frac,
  output logic              best_mode
);
  import tu_calc_pkg::*;

  logic [W-1:0] best_err_r;
  logic         take;

  assign take = cand_valid && (cand_err < best_err_r);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      best_err_r <= W'(INIT_BOUND);
      found      <= 1'b0;
      best_tu    <= '0;
      best_int   <= '0;
      best_frac  <= '0;
      best_mode  <= 1'b0;
    end else if (take) begin
      best_err_r <= cand_err;
      found      <= 1'b1;
      best_tu    <= cand_tu;
      best_int   <= cand_int;
      best_frac  <= cand_frac;
      best_mode  <= cand_mode;
    end
  end

  // R4: the kept error never grows during a walk
  a_r4_err_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && !clear) |=> best_err_r <= $past(best_err_r));
endmodule

// File: rtl/tu_word_pack.sv
module tu_word_pack #(
  parameter int TU_W    = 7,
  parameter int INT_W   = 7,
  parameter int FRAC_W  = 4,
  parameter int EXTRA_W = 6
) (
  input  logic [TU_W-1:0]    tu,
  input  logic [INT_W-1:0]   fill_int,
  input  logic [FRAC_W-1:0]  frac,
  input  logic               mode,
  input  logic [EXTRA_W-1:0] extra,
  output logic [31:0]        tu_word,
  output logic [31:0]        fill_word
);
  import tu_calc_pkg::*;

  always_comb begin
    tu_word                          = '0;
    tu_word[TU_LSB +: TU_W]          = tu;
    fill_word                        = '0;
    fill_word[MODE_BIT]              = mode;
    fill_word[FRAC_LSB +: FRAC_W]    = frac;
    fill_word[INT_LSB +: INT_W]      = fill_int;
    fill_word[EXTRA_LSB +: EXTRA_W]  = extra;
  end
endmodule

// File: rtl/tu_fill_calc.sv
module tu_fill_calc #(
  parameter int PCLK_W = 20,
  parameter int BPP_W  = 8,
  parameter int LANE_W = 3,
  parameter int DIV_W  = 64,
  parameter int TU_MAX = 64,
  parameter int TU_MIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PCLK_W-1:0] pclk_khz,
  input  logic [BPP_W-1:0]  bpp,
  input  logic [LANE_W-1:0] lanes,
  input  logic              rate_hi,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [31:0]       tu_word,
  output logic [31:0]       fill_word
);
  import tu_calc_pkg::*;

  localparam int W       = DIV_W;
  localparam int TU_W    = $clog2(TU_MAX + 1);
  localparam int INT_W   = 7;
  localparam int FRAC_W  = 4;
  localparam int EXTRA_W = 6;
  localparam int PB_W    = PCLK_W + BPP_W;

  calc_state_e state_r;

  logic [W-1:0]      rate_r, lbw_r, ratio_r, vtui_r, rem_r, add_r, tmp_r;
  logic [TU_W-1:0]   tu_r;
  logic [FRAC_W-1:0] frac_r;
  logic              mode_r, issued_r, done_r, fail_r;
  logic [31:0]       tu_word_r, fill_word_r;

  logic              div_start, div_done, div_state;
  logic [W-1:0]      div_a, div_b, div_q, div_rm;
  logic [W-1:0]      tv_w, dist_w, cand_err;
  logic [PB_W-1:0]   prod_w;
  logic [2:0]        shift_w;

  logic              best_found, best_mode, clear_best, cand_valid;
  logic [TU_W-1:0]   best_tu;
  logic [INT_W-1:0]  best_int;
  logic [FRAC_W-1:0] best_frac;
  logic [EXTRA_W-1:0] extra_w;
  logic [31:0]       pack_tu, pack_fill;

  // lane count is a power of two, so the per-lane divide is a shift
  assign prod_w = PB_W'(pclk_khz) * PB_W'(bpp);
  always_comb begin
    case (lanes)
      LANE_W'(1): shift_w = 3'd3;
      LANE_W'(2): shift_w = 3'd4;
      default:    shift_w = 3'd5;
    endcase
  end

  assign tv_w     = ratio_r * W'(tu_r);
  assign dist_w   = W'(SYM) - rem_r;
  assign cand_err = add_r - rem_r;

  always_comb begin
    div_a = '0;
    div_b = W'(1);
    div_state = 1'b1;
    case (state_r)
      ST_RATIO:    begin div_a = rate_r * W'(SYM);               div_b = lbw_r;       end
      ST_TV:       begin div_a = tv_w;                           div_b = W'(SYM);     end
      ST_HI_CEIL:  begin div_a = W'(SYM) + dist_w - W'(1);       div_b = dist_w;      end
      ST_HI_RECIP: begin div_a = W'(SYM);                        div_b = W'(frac_r);  end
      ST_LO_RECIP: begin div_a = W'(SYM);                        div_b = rem_r;       end
      ST_LO_ADD:   begin div_a = W'(SYM);                        div_b = W'(frac_r);  end
      ST_EXTRA1:   begin div_a = (W'(SYM) - ratio_r) * W'(best_tu) * ratio_r;
                         div_b = W'(SYM); end
      ST_EXTRA2:   begin div_a = tmp_r;                          div_b = W'(SYM);     end
      default:     div_state = 1'b0;
    endcase
  end

  assign div_start  = div_state && !issued_r;
  assign clear_best = (state_r == ST_IDLE) && start;
  assign cand_valid = (state_r == ST_EVAL);
  assign extra_w    = EXTRA_W'(div_q + W'(EXTRA_BIAS));

  tu_divider #(.W(W)) div_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (div_start),
    .dividend  (div_a),
    .divisor   (div_b),
    .done      (div_done),
    .quotient  (div_q),
    .remainder (div_rm)
  );

  tu_best_track #(.W(W), .TU_W(TU_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) best_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear_best),
    .cand_valid (cand_valid),
    .cand_err   (cand_err),
    .cand_tu    (tu_r),
    .cand_int   (INT_W'(vtui_r)),
    .cand_frac  (frac_r),
    .cand_mode  (mode_r),
    .found      (best_found),
    .best_tu    (best_tu),
    .best_int   (best_int),
    .best_frac  (best_frac),
    .best_mode  (best_mode)
  );

  tu_word_pack #(.TU_W(TU_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .EXTRA_W(EXTRA_W)) pack_i (
    .tu        (best_tu),
    .fill_int  (best_int),
    .frac      (best_frac),
    .mode      (best_mode),
    .extra     (extra_w),
    .tu_word   (pack_tu),
    .fill_word (pack_fill)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_r     <= ST_IDLE;
      rate_r      <= '0;
      lbw_r       <= '0;
      ratio_r     <= '0;
      vtui_r      <= '0;
      rem_r       <= '0;
      add_r       <= '0;
      tmp_r       <= '0;
      tu_r        <= '0;
      frac_r      <= '0;
      mode_r      <= 1'b0;
      issued_r    <= 1'b0;
      done_r      <= 1'b0;
      fail_r      <= 1'b0;
      tu_word_r   <= '0;
      fill_word_r <= '0;
    end else begin
      done_r <= 1'b0;
      if (div_start) issued_r <= 1'b1;
      if (div_done)  issued_r <= 1'b0;
      case (state_r)
        ST_IDLE: if (start) begin
          rate_r  <= W'(prod_w >> shift_w);
          lbw_r   <= rate_hi ? W'(RATE_HI) : W'(RATE_LO);
          tu_r    <= TU_W'(TU_MAX);
          state_r <= ST_RATIO;
        end
        ST_RATIO: if (div_done) begin
          ratio_r <= div_q;
          state_r <= ST_TV;
        end
        ST_TV: if (div_done) begin
          if (div_rm == '0) begin
            vtui_r  <= div_q - W'(1);
            rem_r   <= '0;
            add_r   <= '0;
            frac_r  <= FRAC_W'(1);
            mode_r  <= 1'b0;
            state_r <= ST_EVAL;
          end else begin
            vtui_r  <= div_q;
            rem_r   <= div_rm;
            state_r <= (div_rm >= W'(HALF_SYM)) ? ST_HI_CEIL : ST_LO_RECIP;
          end
        end
        ST_HI_CEIL: if (div_done) begin
          if (div_q <= W'(FRAC_CAP)) begin
            frac_r  <= FRAC_W'(div_q);
            state_r <= ST_HI_RECIP;
          end else begin
            frac_r  <= FRAC_W'(1);
            mode_r  <= 1'b0;
            add_r   <= W'(SYM);
            state_r <= ST_EVAL;
          end
        end
        ST_HI_RECIP: if (div_done) begin
          add_r   <= W'(SYM) - div_q;
          mode_r  <= 1'b1;
          state_r <= ST_EVAL;
        end
        ST_LO_RECIP: if (div_done) begin
          frac_r  <= (div_q > W'(FRAC_CAP)) ? FRAC_W'(FRAC_CAP) : FRAC_W'(div_q);
          state_r <= ST_LO_ADD;
        end
        ST_LO_ADD: if (div_done) begin
          add_r   <= div_q;
          mode_r  <= 1'b0;
          state_r <= ST_EVAL;
        end
        ST_EVAL: begin
          if (cand_err == '0 || tu_r == TU_W'(TU_MIN)) begin
            state_r <= ST_FIN;
          end else begin
            tu_r    <= tu_r - 1'b1;
            state_r <= ST_TV;
          end
        end
        ST_FIN: begin
          if (!best_found) begin
            fail_r  <= 1'b1;
            done_r  <= 1'b1;
            state_r <= ST_IDLE;
          end else begin
            state_r <= ST_EXTRA1;
          end
        end
        ST_EXTRA1: if (div_done) begin
          tmp_r   <= div_q;
          state_r <= ST_EXTRA2;
        end
        ST_EXTRA2: if (div_done) begin
          tu_word_r   <= pack_tu;
          fill_word_r <= pack_fill;
          fail_r      <= 1'b0;
          done_r      <= 1'b1;
          state_r     <= ST_IDLE;
        end
        default: state_r <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_r != ST_IDLE);
  assign done      = done_r;
  assign fail      = fail_r;
  assign tu_word   = tu_word_r;
  assign fill_word = fill_word_r;

  // R2: completion is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: an accepted request makes the block busy on the next cycle
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R2: completion is reported with busy already low
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R11: results hold between completions
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(tu_word) && $stable(fill_word) && $stable(fail)));
  // R9: a reported fraction is never zero
  a_r9_frac_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> fill_word[FRAC_LSB +: FRAC_W] != '0);
  // R5: the reciprocal mode always carries a fraction of at least two
  a_r5_mode_frac_min: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail && fill_word[MODE_BIT]) |-> fill_word[FRAC_LSB +: FRAC_W] >= FRAC_W'(2));
  // R4: the chosen size lies inside the walked range
  a_r4_tu_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> (tu_word[TU_LSB +: TU_W] >= TU_W'(TU_MIN) &&
                         tu_word[TU_LSB +: TU_W] <= TU_W'(TU_MAX)));
endmodule

// File: tb/tu_fill_calc_tb_top.sv
module tu_fill_calc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] pclk_khz = '0;
  logic [7:0]  bpp = '0;
  logic [2:0]  lanes = 3'd1;
  logic        rate_hi = 1'b0;
  logic        busy, done, fail;
  logic [31:0] tu_word, fill_word;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  tu_fill_calc dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pclk_khz  (pclk_khz),
    .bpp       (bpp),
    .lanes     (lanes),
    .rate_hi   (rate_hi),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .tu_word   (tu_word),
    .fill_word (fill_word)
  );

  localparam longint unsigned S = 100000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint unsigned lane_rate(input int unsigned pk, input int unsigned bp,
                                                input int unsigned ln);
    longint unsigned r;
    r = (longint'(pk) * longint'(bp)) / 8;
    if (ln == 1) return r;
    if (ln == 2) return r / 2;
    return r / 4;
  endfunction

  // reference built from R3..R9
  function automatic void model(input int unsigned pk, input int unsigned bp, input int unsigned ln,
                                input bit hi, output logic [31:0] tw, output logic [31:0] fw,
                                output string tag);
    longint unsigned ratio, best, tgt, vi, rm, dd, c, fr, err, ex, bvi, bfr;
    int unsigned btu;
    bit md, bmd;
    string t;
    ratio = lane_rate(pk, bp, ln) * S / (hi ? 64'd270000 : 64'd162000);
    best = 64 * S;
    btu = 0; bvi = 0; bfr = 0; bmd = 0; tag = "R6";
    for (int tu = 64; tu >= 32; tu--) begin
      tgt = ratio * longint'(tu);
      vi = tgt / S;
      rm = tgt % S;
      if (rm == 0) begin
        vi = vi - 1; md = 0; fr = 1; err = 0; t = "R7";
      end else if (rm >= 50000) begin
        dd = S - rm;
        c = (S + dd - 1) / dd;
        t = "R5";
        if (c <= 15) begin md = 1; fr = c; err = (S - S / c) - rm; end
        else begin md = 0; fr = 1; err = S - rm; end
      end else begin
        fr = S / rm;
        if (fr > 15) fr = 15;
        md = 0; err = S / fr - rm; t = "R6";
      end
      if (err < best) begin
        best = err; btu = tu; bvi = vi; bfr = fr; bmd = md; tag = t;
        if (err == 0) break;
      end
    end
    ex = ((S - ratio) * longint'(btu) * ratio) / S / S + 6;
    tw = 32'(btu[6:0]) << 2;
    fw = (32'(bmd) << 24) | (32'(bfr[3:0]) << 16) | (32'(bvi[6:0]) << 8) | 32'(ex[5:0]);
  endfunction

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 12000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    if (!ok) chk("R2 done timeout", 32'd0, 32'd1);
  endtask

  task automatic run_vec(input int unsigned pk, input int unsigned bp, input int unsigned ln,
                         input bit hi);
    logic [31:0] etw, efw;
    string tag;
    bit ok;
    model(pk, bp, ln, hi, etw, efw, tag);
    @(negedge clk);
    pclk_khz = 20'(pk); bpp = 8'(bp); lanes = 3'(ln); rate_hi = hi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", 32'(busy), 32'd1);
    pclk_khz = 20'($urandom); bpp = 8'($urandom); lanes = 3'($urandom); rate_hi = 1'($urandom);
    wait_done(ok);
    if (ok) begin
      chk("R2 busy low at done", 32'(busy), 32'd0);
      chk("R4 size field", tu_word, etw);
      chk({tag, " fraction and mode"}, fill_word & 32'h010F_0000, efw & 32'h010F_0000);
      chk({tag, " integer field"}, fill_word & 32'h0000_7F00, efw & 32'h0000_7F00);
      chk("R8 extra field", fill_word & 32'h3F, efw & 32'h3F);
      chk("R9 packed word", fill_word, efw);
      chk("R10 fail low", 32'(fail), 32'd0);
      @(negedge clk);
      chk("R2 done one cycle", 32'(done), 32'd0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] etw, efw, tw4, fw4;
    string tag;
    bit ok;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 fail", 32'(fail), 32'd0);
    chk("R1 tu_word", tu_word, 32'd0);
    chk("R1 fill_word", fill_word, 32'd0);

    // R7 / R9: ratio 50000 gives a zero remainder at size 64
    run_vec(27000, 24, 1, 1'b0);
    chk("R7 literal size", tu_word, 32'h0000_0100);
    chk("R9 literal fill", fill_word, 32'h0001_1F16);

    // R11: words hold while inputs move without a request
    pclk_khz = 20'd99999; bpp = 8'd30; lanes = 3'd2;
    repeat (20) @(negedge clk);
    chk("R11 size held", tu_word, 32'h0000_0100);
    chk("R11 fill held", fill_word, 32'h0001_1F16);

    // R3: lane code 3 behaves as four lanes
    run_vec(297000, 24, 3, 1'b1);
    model(297000, 24, 4, 1'b1, tw4, fw4, tag);
    chk("R3 lane code 3 size", tu_word, tw4);
    chk("R3 lane code 3 fill", fill_word, fw4);
    run_vec(148500, 24, 2, 1'b1);
    run_vec(65000, 18, 1, 1'b0);

    // R2: a second request during a busy run is ignored
    model(108000, 24, 2, 1'b0, etw, efw, tag);
    @(negedge clk);
    pclk_khz = 20'd108000; bpp = 8'd24; lanes = 3'd2; rate_hi = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    pclk_khz = 20'd40000; bpp = 8'd18; lanes = 3'd1; rate_hi = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    if (ok) begin
      chk("R2 late start ignored size", tu_word, etw);
      chk("R2 late start ignored fill", fill_word, efw);
    end

    for (int k = 0; k < 12; k++) begin
      int unsigned pk, bp, ln;
      bit hi;
      int unsigned bsel, lsel;
      do begin
        pk = $urandom_range(25000, 600000);
        bsel = $urandom_range(0, 3);
        bp = 18 + 6 * bsel;
        lsel = $urandom_range(0, 2);
        ln = (lsel == 0) ? 1 : ((lsel == 1) ? 2 : 4);
        hi = 1'($urandom);
      end while (lane_rate(pk, bp, ln) > (hi ? 64'd270000 : 64'd162000) ||
                 lane_rate(pk, bp, ln) < 64'd2000);
      run_vec(pk, bp, ln, hi);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule